// File: doc/BRIEF.md
# DDR Pixel Frame Receiver

This block sits on the acquisition side of a zero-suppressed pixel sensor link. It runs on the clock that the sensor forwards with its data. It samples one or two serial lines on both clock edges and joins each rising/falling pair into a two-bit step. A frame-start strobe aligns the step stream into 30-bit words, which arrive least significant bit first.

A small parser walks each frame in order. It expects a header, a trigger word, a word carrying the frame counter and the data length, the data words, and finally a trailer. The data words leave on a valid/ready stream. Each word carries its link index, first/last markers and the frame counter. A buffer sized for two full frames absorbs back-pressure. Framing faults, skipped frames and buffer overflow raise sticky flags that stay set until reset. A parameter selects the sensor variant, which sets the maximum data length.

Top module: `pixframe_rx`

## Requirements
- R1: Each clock contributes the bit sampled at the rising edge and then the bit sampled at the falling edge. Words are 30 bits, least significant bit first, so 15 clocks make one word per link. A strobe sampled high at a rising edge marks that edge's bit as bit 0 of a header word.
- R2: A strobe-aligned word opens a frame only if it equals the link-0 header value, and, in dual mode, link 1 also equals the link-1 header value. On a mismatch `err_hdr` is set, nothing is output and the receiver keeps hunting for the next strobe.
- R3: After the header come one trigger word (discarded) and a counter word: frame counter in bits [29:14], data length in bits [13:0]. Exactly that many data words are taken before the trailer. A length of 0 goes straight to the trailer and outputs nothing.
- R4: A length above the variant maximum sets `err_len`, outputs nothing and returns to hunting. The maximum is 416 with `VARIANT`=0 and 208 with `VARIANT`=1, and a length equal to the maximum is accepted.
- R5: A trailer that differs from the expected value on any active link sets `err_trl`. Data words already delivered are unaffected.
- R6: Each accepted counter word must hold the previous one plus 1, modulo 2^16; otherwise `err_skip` is set. The first counter word after reset is not checked.
- R7: With `dual_mode`=1, each data index yields the link-0 word (`m_link`=0) and then the link-1 word (`m_link`=1). With `dual_mode`=0, only link 0 is used and `line1` has no effect. Link 1 is always paced by the length in link 0's counter word.
- R8: On each link, `m_first` marks data index 0 and `m_last` marks the last index. Both are set when the length is 1.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` and all output fields hold.
- R10: The block holds at most 2^ceil(log2(2*max)) + 1 words (1025 by default, counting the output register). Further words are dropped and `err_ovf` is set.
- R11: A strobe that arrives while a frame is being parsed has no effect.
- R12: Reset clears `m_valid` and all error flags. Once set, an error flag stays set until reset.
- R13: `m_fcnt` carries the frame counter of the frame the word belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded sensor clock; data sampled on both edges |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1: two links, 0: link 0 only |
| mark_in | input | 1 | Frame-start strobe |
| line0 | input | 1 | Serial data link 0 |
| line1 | input | 1 | Serial data link 1 |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | 30 | Data word |
| m_link | output | 1 | Link index of the word |
| m_first | output | 1 | First data word of the frame on this link |
| m_last | output | 1 | Last data word of the frame on this link |
| m_fcnt | output | 16 | Frame counter of the word's frame |
| err_hdr | output | 1 | Sticky header mismatch |
| err_trl | output | 1 | Sticky trailer mismatch |
| err_len | output | 1 | Sticky length above maximum |
| err_skip | output | 1 | Sticky frame counter discontinuity |
| err_ovf | output | 1 | Sticky buffer overflow |

## Verification
Two functions can act in the same cycle: the parser pushes a word into the output buffer while the consumer pops one, and the buffer drops a word while the output register is stalled. The first case is provoked with a randomly toggling ready during dual-link frames; it is judged by comparing every accepted output word, in order, against a queue that the bench fills as it serialises the frames. The second case is provoked by holding ready low across two maximum-length dual frames; it is judged by checking that exactly the first 1025 queued words come out once ready rises, and that the overflow flag is set.

// File: rtl/pixframe_pkg.sv
`timescale 1ns/1ps
package pixframe_pkg;
  localparam int WORD_W = 30;
  localparam int FC_W   = 16;
  localparam int LEN_W  = 14;

  typedef enum logic [2:0] {ST_HUNT, ST_TRIG, ST_CNT, ST_DATA, ST_TRL} pf_state_e;

  typedef struct packed {
    logic [FC_W-1:0]   fcnt;
    logic              last;
    logic              first;
    logic              link;
    logic [WORD_W-1:0] data;
  } pf_entry_t;

  function automatic int max_words(int variant);
    return (variant != 0) ? 208 : 416;
  endfunction
endpackage

// File: rtl/pixframe_deser.sv
`timescale 1ns/1ps
// Double-edge capture and 30-bit word alignment for one link (R1, R11)
module pixframe_deser #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              mark,
  input  logic              hunt,
  output logic              word_v,
  output logic [WORD_W-1:0] word,
  output logic              word_first
);
  localparam int PAIRS = WORD_W / 2;
  localparam int CW    = $clog2(PAIRS);

  logic              rise_q, fall_q, mark_q, first_pend, restart;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sr, nxt;

  always_ff @(negedge clk) fall_q <= line;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      rise_q <= line;
      mark_q <= mark;
    end
  end

  // rising-edge bit is older, so it lands below the falling-edge bit
  assign nxt     = {fall_q, rise_q, sr[WORD_W-1:2]};
  assign restart = mark_q & hunt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      cnt        <= '0;
      first_pend <= 1'b0;
      word_v     <= 1'b0;
      word       <= '0;
      word_first <= 1'b0;
    end else begin
      sr     <= nxt;
      word_v <= 1'b0;
      if (restart) begin
        cnt        <= CW'(1);
        first_pend <= 1'b1;
      end else if (cnt == CW'(PAIRS-1)) begin
        cnt        <= '0;
        word_v     <= 1'b1;
        word       <= nxt;
        word_first <= first_pend;
        first_pend <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pixframe_parser.sv
`timescale 1ns/1ps
// Frame walker: header, trigger, counter/length, data, trailer (R2-R8, R13)
module pixframe_parser
  import pixframe_pkg::*;
#(
  parameter int                MAXW = 416,
  parameter logic [WORD_W-1:0] HDR0 = 30'h15A5_0F31,
  parameter logic [WORD_W-1:0] HDR1 = 30'h15A5_0F32,
  parameter logic [WORD_W-1:0] TRL0 = 30'h2E7C_11A0,
  parameter logic [WORD_W-1:0] TRL1 = 30'h2E7C_11A1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dual,
  input  logic [1:0]        w_v,
  input  logic [1:0]        w_first,
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  output logic              hunt,
  output logic              push_v,
  output pf_entry_t         push_e,
  output logic              err_hdr,
  output logic              err_trl,
  output logic              err_len,
  output logic              err_skip
);
  pf_state_e        state;
  logic [FC_W-1:0]  fc_q, prev_fc;
  logic [LEN_W-1:0] len_q, idx;
  logic             have_prev, pend_v, any_v, start_ok, is_last;
  pf_entry_t        pend_e;
  logic [FC_W-1:0]  fc_in;
  logic [LEN_W-1:0] len_in;

  assign any_v    = |w_v;
  assign hunt     = (state == ST_HUNT);
  assign fc_in    = w0[WORD_W-1 -: FC_W];
  assign len_in   = w0[LEN_W-1:0];
  assign start_ok = w_first[0] & (w_first[1] | ~dual);
  assign is_last  = (idx == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      fc_q      <= '0;
      prev_fc   <= '0;
      len_q     <= '0;
      idx       <= '0;
      have_prev <= 1'b0;
      pend_v    <= 1'b0;
      pend_e    <= '0;
      push_v    <= 1'b0;
      push_e    <= '0;
      err_hdr   <= 1'b0;
      err_trl   <= 1'b0;
      err_len   <= 1'b0;
      err_skip  <= 1'b0;
    end else begin
      push_v <= 1'b0;
      if (pend_v) begin
        push_v <= 1'b1;
        push_e <= pend_e;
        pend_v <= 1'b0;
      end
      if (any_v) begin
        unique case (state)
          ST_HUNT: if (start_ok) begin
            if (w0 == HDR0 && (!dual || w1 == HDR1)) state <= ST_TRIG;
            else err_hdr <= 1'b1;
          end
          ST_TRIG: state <= ST_CNT;
          ST_CNT: begin
            if (have_prev && fc_in != prev_fc + FC_W'(1)) err_skip <= 1'b1;
            prev_fc   <= fc_in;
            have_prev <= 1'b1;
            fc_q      <= fc_in;
            len_q     <= len_in;
            idx       <= '0;
            if (len_in > LEN_W'(MAXW)) begin
              err_len <= 1'b1;
              state   <= ST_HUNT;
            end else if (len_in == '0) state <= ST_TRL;
            else state <= ST_DATA;
          end
          ST_DATA: begin
            push_v <= 1'b1;
            push_e <= '{fcnt: fc_q, last: is_last, first: (idx == '0), link: 1'b0, data: w0};
            if (dual) begin
              pend_v <= 1'b1;
              pend_e <= '{fcnt: fc_q, last: is_last, first: (idx == '0), link: 1'b1, data: w1};
            end
            idx <= idx + LEN_W'(1);
            if (is_last) state <= ST_TRL;
          end
          ST_TRL: begin
            if (w0 != TRL0 || (dual && w1 != TRL1)) err_trl <= 1'b1;
            state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/pixframe_fifo.sv
`timescale 1ns/1ps
// Output buffer with registered read port and sticky overflow (R9, R10)
module pixframe_fifo #(
  parameter int W  = 49,
  parameter int AW = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_v,
  input  logic [W-1:0] wr_d,
  input  logic         rd_ready,
  output logic         out_v,
  output logic [W-1:0] out_d,
  output logic         ovf
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          wr_ok, pop;

  assign wr_ok = wr_v && (count != (AW+1)'(DEPTH));
  assign pop   = (count != '0) && (!out_v || rd_ready);

  always_ff @(posedge clk) if (wr_ok) mem[wp] <= wr_d;
  always_ff @(posedge clk) if (pop) out_d <= mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      out_v <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      count <= count + (AW+1)'(wr_ok) - (AW+1)'(pop);
      if (pop) out_v <= 1'b1;
      else if (rd_ready) out_v <= 1'b0;
      if (wr_v && !wr_ok) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pixframe_rx.sv
`timescale 1ns/1ps
module pixframe_rx
  import pixframe_pkg::*;
#(
  parameter int                VARIANT = 0,
  parameter logic [WORD_W-1:0] HDR0    = 30'h15A5_0F31,
  parameter logic [WORD_W-1:0] HDR1    = 30'h15A5_0F32,
  parameter logic [WORD_W-1:0] TRL0    = 30'h2E7C_11A0,
  parameter logic [WORD_W-1:0] TRL1    = 30'h2E7C_11A1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dual_mode,
  input  logic              mark_in,
  input  logic              line0,
  input  logic              line1,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_link,
  output logic              m_first,
  output logic              m_last,
  output logic [FC_W-1:0]   m_fcnt,
  output logic              err_hdr,
  output logic              err_trl,
  output logic              err_len,
  output logic              err_skip,
  output logic              err_ovf
);
  localparam int MAXW    = max_words(VARIANT);
  localparam int FIFO_AW = $clog2(2 * MAXW);
  localparam int ENTRY_W = $bits(pf_entry_t);
  localparam int NLINK   = 2;

  logic [NLINK-1:0]  lines, wv, wf;
  logic [WORD_W-1:0] wd [NLINK];
  logic              hunt, push_v;
  pf_entry_t         push_e, out_e;
  logic [ENTRY_W-1:0] out_raw;

  assign lines = {line1, line0};

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    pixframe_deser #(.WORD_W(WORD_W)) deser_i (
      .clk(clk), .rst(rst), .line(lines[g]), .mark(mark_in), .hunt(hunt),
      .word_v(wv[g]), .word(wd[g]), .word_first(wf[g])
    );
  end

  pixframe_parser #(
    .MAXW(MAXW), .HDR0(HDR0), .HDR1(HDR1), .TRL0(TRL0), .TRL1(TRL1)
  ) parser_i (
    .clk(clk), .rst(rst), .dual(dual_mode), .w_v(wv), .w_first(wf),
    .w0(wd[0]), .w1(wd[1]), .hunt(hunt), .push_v(push_v), .push_e(push_e),
    .err_hdr(err_hdr), .err_trl(err_trl), .err_len(err_len), .err_skip(err_skip)
  );

  pixframe_fifo #(.W(ENTRY_W), .AW(FIFO_AW)) fifo_i (
    .clk(clk), .rst(rst), .wr_v(push_v), .wr_d(push_e), .rd_ready(m_ready),
    .out_v(m_valid), .out_d(out_raw), .ovf(err_ovf)
  );

  assign out_e   = pf_entry_t'(out_raw);
  assign m_data  = out_e.data;
  assign m_link  = out_e.link;
  assign m_first = out_e.first;
  assign m_last  = out_e.last;
  assign m_fcnt  = out_e.fcnt;
endmodule

// File: rtl/pixframe_rx_chk.sv
`timescale 1ns/1ps
module pixframe_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        m_valid,
  input logic        m_ready,
  input logic [29:0] m_data,
  input logic        m_link,
  input logic        m_first,
  input logic        m_last,
  input logic [15:0] m_fcnt,
  input logic        err_hdr,
  input logic        err_trl,
  input logic        err_len,
  input logic        err_skip,
  input logic        err_ovf
);
  logic [1:0] open_q;
  logic [4:0] errs;
  assign errs = {err_hdr, err_trl, err_len, err_skip, err_ovf};

  always_ff @(posedge clk) begin
    if (rst) open_q <= '0;
    else if (m_valid && m_ready) begin
      if (m_last) open_q[m_link] <= 1'b0;
      else if (m_first) open_q[m_link] <= 1'b1;
    end
  end

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid);
  // R9
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> $stable({m_data, m_link, m_first, m_last, m_fcnt}));
  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((errs & $past(errs)) == $past(errs)));
  // R12
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!m_valid && errs == '0));
  // R8
  first_opens_chk: assert property (@(posedge clk) disable iff (rst || err_ovf)
    m_valid && m_ready && m_first |-> !open_q[m_link]);
  // R8
  middle_open_chk: assert property (@(posedge clk) disable iff (rst || err_ovf)
    m_valid && m_ready && !m_first |-> open_q[m_link]);
endmodule

bind pixframe_rx pixframe_rx_chk chk_i (.*);

// File: tb/pixframe_rx_tb.sv
`timescale 1ns/1ps
module pixframe_rx_tb_top;
  localparam logic [29:0] H0 = 30'h15A5_0F31, H1 = 30'h15A5_0F32;
  localparam logic [29:0] T0 = 30'h2E7C_11A0, T1 = 30'h2E7C_11A1;
  localparam int MAXW = 416;
  localparam int CAP  = (1 << $clog2(2 * MAXW)) + 1;

  logic clk = 0, rst = 1, dual_mode = 0, mark_in = 0, line0 = 0, line1 = 0, m_ready = 0;
  logic m_valid, m_link, m_first, m_last, err_hdr, err_trl, err_len, err_skip, err_ovf;
  logic [29:0] m_data;
  logic [15:0] m_fcnt;

  int total = 0, bad = 0, rdy_mode = 1;
  bit junk1 = 0, ovf_mode = 0, stalled = 0;
  logic [48:0] q[$];
  logic [48:0] held;

  always #2.5 clk = ~clk;

  pixframe_rx dut_i (.*);

  always @(posedge clk) begin
    #1;
    m_ready <= (rdy_mode == 2) ? 1'($urandom_range(0, 1)) : (rdy_mode == 1);
  end

  // reference stream compare and hold check (R1, R7, R9, R13)
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        total++;
        if (!m_valid || {m_fcnt, m_last, m_first, m_link, m_data} != held) begin
          bad++;
          $display("FAIL R9 held output changed: got %h exp %h", {m_fcnt, m_last, m_first, m_link, m_data}, held);
        end
      end
      stalled = m_valid && !m_ready;
      held = {m_fcnt, m_last, m_first, m_link, m_data};
      if (m_valid && m_ready) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R7 unexpected word: got %h exp none", held);
        end else begin
          logic [48:0] e;
          e = q.pop_front();
          if (held != e) begin
            bad++;
            $display("FAIL R1/R13 word mismatch: got %h exp %h", held, e);
          end
        end
      end
    end else stalled = 0;
  end

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic send_pair(bit r0, bit f0, bit r1, bit f1, bit mk);
    @(negedge clk);
    #0.5;
    line0 = r0; line1 = junk1 ? 1'($urandom_range(0, 1)) : r1; mark_in = mk;
    @(posedge clk);
    #0.5;
    line0 = f0; line1 = junk1 ? 1'($urandom_range(0, 1)) : f1; mark_in = 0;
  endtask

  task automatic send_words(logic [29:0] a, logic [29:0] b, bit mk);
    for (int i = 0; i < 15; i++) send_pair(a[2*i], a[2*i+1], b[2*i], b[2*i+1], mk && i == 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send_pair(0, 0, 0, 0, 0);
  endtask

  function automatic logic [29:0] dword(int fc, int link, int i);
    return 30'(fc * 977 + i * 131 + link * 50021) ^ 30'h2345678;
  endfunction

  task automatic expect_word(logic [15:0] fc, bit last, bit first, bit link, logic [29:0] d);
    if (!ovf_mode || q.size() < CAP) q.push_back({fc, last, first, link, d});
  endtask

  task automatic frame(bit dual, int fc, int len, int nsend, bit bad_hdr, bit bad_trl, bit exp_out, bit mid_mark);
    dual_mode = dual;
    send_words(bad_hdr ? (H0 ^ 30'h1) : H0, H1, 1);
    send_words(30'h0ABC_DE01, 30'h0ABC_DE02, 0);
    send_words({16'(fc), 14'(len)}, {16'(fc), 14'(len)}, 0);
    for (int i = 0; i < nsend; i++) begin
      if (exp_out) begin
        expect_word(16'(fc), i == len - 1, i == 0, 0, dword(fc, 0, i));
        if (dual) expect_word(16'(fc), i == len - 1, i == 0, 1, dword(fc, 1, i));
      end
      send_words(dword(fc, 0, i), dword(fc, 1, i), mid_mark && i == 1);
    end
    send_words(bad_trl ? (T0 ^ 30'h2) : T0, T1, 0);
    idle(4);
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R7 words missing: got %0d left exp 0", q.size());
    end
  endtask

  task automatic do_reset();
    rst = 1;
    q.delete();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R12 valid after reset", m_valid, 0);
    chk("R12 errors after reset", |{err_hdr, err_trl, err_len, err_skip, err_ovf}, 0);
  endtask

  task automatic no_err(string tag);
    chk({tag, " no error"}, |{err_hdr, err_trl, err_len, err_skip, err_ovf}, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R7 single link, link 1 ignored; R3 lengths
    junk1 = 1;
    frame(0, 10, 5, 5, 0, 0, 1, 0);
    drain(); no_err("R7 single");
    junk1 = 0;
    // R7 R8 dual under random back-pressure
    rdy_mode = 2;
    frame(1, 11, 3, 3, 0, 0, 1, 0);
    drain(); no_err("R7 dual");
    frame(1, 12, 1, 1, 0, 0, 1, 0);           // R8 single word: first and last
    drain(); no_err("R8 len1");
    frame(1, 13, 0, 0, 0, 0, 1, 0);           // R3 zero length
    drain(); no_err("R3 len0");
    frame(1, 14, 4, 4, 0, 0, 1, 1);           // R11 stray strobe mid-frame
    drain(); no_err("R11 stray strobe");
    rdy_mode = 1;

    // R6 wrap and skip
    do_reset();
    frame(1, 16'hFFFF, 2, 2, 0, 0, 1, 0);
    frame(1, 0, 2, 2, 0, 0, 1, 0);
    drain(); chk("R6 wrap no skip", err_skip, 0);
    frame(1, 2, 2, 2, 0, 0, 1, 0);
    drain(); chk("R6 skip flagged", err_skip, 1);
    frame(1, 3, 1, 1, 0, 0, 1, 0);
    drain(); chk("R12 skip sticky", err_skip, 1);

    // R2 bad header then recovery
    do_reset();
    frame(1, 20, 3, 3, 1, 0, 0, 0);
    chk("R2 header error", err_hdr, 1);
    frame(1, 21, 2, 2, 0, 0, 1, 0);
    drain(); chk("R2 recovery no trailer error", err_trl, 0);

    // R5 trailer mismatch
    do_reset();
    frame(1, 30, 2, 2, 0, 1, 1, 0);
    drain(); chk("R5 trailer error", err_trl, 1);

    // R4 length above and at the maximum
    do_reset();
    frame(0, 50, MAXW + 1, 3, 0, 0, 0, 0);
    chk("R4 length error", err_len, 1);
    frame(0, 51, MAXW, MAXW, 0, 0, 1, 0);
    drain(); chk("R4 max length accepted no skip", err_skip, 0);

    // R10 overflow with stalled consumer
    do_reset();
    rdy_mode = 0; ovf_mode = 1;
    frame(1, 40, MAXW, MAXW, 0, 0, 1, 0);
    frame(1, 41, MAXW, MAXW, 0, 0, 1, 0);
    chk("R10 overflow flagged", err_ovf, 1);
    total++;
    if (q.size() != CAP) begin
      bad++;
      $display("FAIL R10 model count: got %0d exp %0d", q.size(), CAP);
    end
    ovf_mode = 0; rdy_mode = 1;
    drain();
    chk("R10 output empty after drain", m_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule